// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This block sits beside an instruction decoder and decides, at every instruction boundary, what the processor does next: restart after a reset request, service a non-maskable interrupt, accept a maskable interrupt, spend an idle cycle while halted, or fetch the next opcode normally. It holds the interrupt-enable state as two flip-flops. The first gates maskable requests. The second keeps a copy that survives a non-maskable interrupt, so that a return can restore it. The block also holds a 2-bit maskable-interrupt mode and an 8-bit vector-base register.

When the decoder raises `boundary`, the request lines are sampled in a fixed priority. One clock later the block issues a single-cycle `take` strobe. With it come a kind code, a service form, a 16-bit target and the cycle cost of the service. The decoder drives single-cycle control pulses for enable, disable, return, mode select, vector-base load and halt. The block updates its registers from these pulses. The decoder stays responsible for stack pushes and bus cycles.

The control state machine has two states: `ST_RUN` and `ST_HALT`. The transition RUN→HALT happens on `halt_cmd` when no service is accepted in the same cycle. The transition HALT→RUN happens when a reset, non-maskable or maskable service is accepted. Power-on reset enters `ST_RUN`.

Top module: `irq_gate_unit`

## Requirements
- R1: When `boundary` is high on a clock edge, `take` is high for exactly the following cycle, and otherwise `take` stays low. Request lines seen without `boundary` change nothing. The choice follows this priority: reset request, then non-maskable, then enabled maskable, then halted idle, then normal fetch. Kind codes: 0 reset, 1 non-maskable, 2 maskable, 3 fetch.
- R2: A non-maskable service gives form 0 (address), target 0x0066 and cost 13. It clears only the first enable flip-flop and leaves the halted state.
- R3: A maskable request is accepted only while the first enable flip-flop (`int_en`) is 1. Acceptance clears both flip-flops and leaves the halted state. A masked request falls through to the idle or fetch choice.
- R4: In mode 0, an accepted maskable interrupt gives form 1 (opcode), target {0x00, data byte} and cost 0.
- R5: In mode 1, an accepted maskable interrupt gives form 0, target 0x0038 and cost 13.
- R6: In mode 2, an accepted maskable interrupt gives form 2 (table pointer), target {vector base, data byte} and cost 19.
- R7: An enable pulse sets both flip-flops and a disable pulse clears both. A return pulse copies the second flip-flop into the first.
- R8: A mode-select pulse with field y gives `im_mode` 0 for y = 0, 1, 4 or 5, mode 1 for y = 2 or 6, and mode 2 for y = 3 or 7.
- R9: After power-on reset, `im_mode` is 0, both flip-flops are 0, `vbase` is 0xFF, `halted` is 0 and `take` is 0. A reset service gives kind 0, form 0, target 0x0000 and cost 3. It clears both flip-flops, leaves the halted state, and keeps the mode and the vector base.
- R10: While halted, a boundary with no accepted request gives kind 3, form 1, target 0x0000 (a no-op opcode) and cost 4, and the block stays halted. When not halted, a plain fetch gives kind 3, form 3 (none), target 0 and cost 0.
- R11: A vector-base load pulse stores `vb_data` in `vbase`. `pv_flag` always shows the second enable flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| boundary | input | 1 | Instruction boundary strobe from the decoder |
| reset_req_n | input | 1 | Reset request, active low |
| nmi_req_n | input | 1 | Non-maskable request, active low |
| int_req_n | input | 1 | Maskable request, active low |
| bus_data | input | 8 | Data-bus byte sampled at the boundary |
| ei_p | input | 1 | Enable-interrupts pulse |
| di_p | input | 1 | Disable-interrupts pulse |
| ret_p | input | 1 | Return-from-interrupt pulse |
| im_p | input | 1 | Mode-select pulse |
| im_y | input | 3 | Opcode field y of the mode-select instruction |
| vb_load | input | 1 | Vector-base load pulse |
| vb_data | input | 8 | Value to load into the vector base |
| halt_cmd | input | 1 | Halt instruction executed |
| take | output | 1 | One-cycle service strobe |
| kind | output | 2 | Service kind code |
| form | output | 2 | Target form: 0 address, 1 opcode, 2 table pointer, 3 none |
| target | output | 16 | Service address, injected opcode or table pointer |
| cost | output | 5 | Cycle cost of the service |
| halted | output | 1 | Halted state |
| int_en | output | 1 | First enable flip-flop |
| pv_flag | output | 1 | Second enable flip-flop, as reported on a vector-base read |
| im_mode | output | 2 | Current maskable mode |
| vbase | output | 8 | Vector-base register |

## Verification
The service outputs (`take`, `kind`, `form`, `target`, `cost`) are registered, so they are due one clock after the edge that sees `boundary`. The enable flip-flops, the mode, the vector base and `halted` change on that same edge. The bench drives every stimulus for exactly one clock from a falling edge and samples at the next falling edge, where all of these results are present together. For the no-effect checks, the bench holds request lines low without a boundary and samples `take` and `int_en` at each falling edge.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic [1:0] {
        KIND_RESET = 2'd0,
        KIND_NMI   = 2'd1,
        KIND_INT   = 2'd2,
        KIND_FETCH = 2'd3
    } take_kind_t;

    typedef enum logic [1:0] {
        FORM_ADDR   = 2'd0,
        FORM_OPCODE = 2'd1,
        FORM_TABLE  = 2'd2,
        FORM_NONE   = 2'd3
    } svc_form_t;

    typedef enum logic [1:0] {
        MODE_INJECT = 2'd0,
        MODE_FIXED  = 2'd1,
        MODE_TABLE  = 2'd2
    } int_mode_t;

    typedef enum logic [2:0] {
        PICK_RESET,
        PICK_NMI,
        PICK_INT,
        PICK_IDLE,
        PICK_FETCH
    } pick_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } cpu_state_t;

endpackage

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_gate_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int VBASE_INIT = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ei_p,
    input  logic              di_p,
    input  logic              ret_p,
    input  logic              im_p,
    input  logic [2:0]        im_y,
    input  logic              vb_load,
    input  logic [DATA_W-1:0] vb_data,
    input  logic              acc_reset,
    input  logic              acc_nmi,
    input  logic              acc_int,
    output logic              iff1,
    output logic              iff2,
    output int_mode_t         mode,
    output logic [DATA_W-1:0] vbase
);

    logic iff1_d, iff2_d;

    function automatic int_mode_t map_mode(input logic [2:0] y);
        int_mode_t m;
        unique case (y)
            3'd2, 3'd6: m = MODE_FIXED;
            3'd3, 3'd7: m = MODE_TABLE;
            default:    m = MODE_INJECT;
        endcase
        return m;
    endfunction

    // acceptance overrides any control pulse of the same cycle
    always_comb begin
        iff1_d = iff1;
        iff2_d = iff2;
        if (acc_reset || acc_int) begin
            iff1_d = 1'b0;
            iff2_d = 1'b0;
        end else if (acc_nmi) begin
            iff1_d = 1'b0;
        end else if (di_p) begin
            iff1_d = 1'b0;
            iff2_d = 1'b0;
        end else if (ei_p) begin
            iff1_d = 1'b1;
            iff2_d = 1'b1;
        end else if (ret_p) begin
            iff1_d = iff2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iff1  <= 1'b0;
            iff2  <= 1'b0;
            mode  <= MODE_INJECT;
            vbase <= DATA_W'(VBASE_INIT);
        end else begin
            iff1 <= iff1_d;
            iff2 <= iff2_d;
            if (im_p)
                mode <= map_mode(im_y);
            if (vb_load)
                vbase <= vb_data;
        end
    end

    a_r2_nmi_keeps_copy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nmi && !acc_reset |=> !iff1 && (iff2 == $past(iff2)));

    a_r3_int_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
        acc_int |=> !iff1 && !iff2);

    a_r7_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        ret_p && !ei_p && !di_p && !acc_reset && !acc_nmi && !acc_int
        |=> iff1 == $past(iff2));

    a_r7_ei_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ei_p && !di_p && !acc_reset && !acc_nmi && !acc_int |=> iff1 && iff2);

    a_r8_mode_six_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        im_p && im_y == 3'd6 |=> mode == MODE_FIXED);

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_gate_pkg::*;
(
    input  logic  reset_req_n,
    input  logic  nmi_req_n,
    input  logic  int_req_n,
    input  logic  iff1,
    input  logic  halted,
    output pick_t pick
);

    always_comb begin
        if (!reset_req_n)
            pick = PICK_RESET;
        else if (!nmi_req_n)
            pick = PICK_NMI;
        else if (!int_req_n && iff1)
            pick = PICK_INT;
        else if (halted)
            pick = PICK_IDLE;
        else
            pick = PICK_FETCH;
    end

endmodule

// File: rtl/irq_service_gen.sv
module irq_service_gen
    import irq_gate_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int COST_W     = 5,
    parameter int RESET_VEC  = 'h0000,
    parameter int NMI_VEC    = 'h0066,
    parameter int FIXED_VEC  = 'h0038,
    parameter int RESET_COST = 3,
    parameter int NMI_COST   = 13,
    parameter int FIXED_COST = 13,
    parameter int TABLE_COST = 19,
    parameter int IDLE_COST  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  pick_t               pick,
    input  int_mode_t           mode,
    input  logic [DATA_W-1:0]   vbase,
    input  logic [DATA_W-1:0]   bus_data,
    output logic                take,
    output take_kind_t          kind,
    output svc_form_t           form,
    output logic [2*DATA_W-1:0] target,
    output logic [COST_W-1:0]   cost
);

    localparam int ADDR_W = 2 * DATA_W;

    take_kind_t          kind_d;
    svc_form_t           form_d;
    logic [ADDR_W-1:0]   tgt_d;
    logic [COST_W-1:0]   cost_d;

    always_comb begin
        kind_d = KIND_FETCH;
        form_d = FORM_NONE;
        tgt_d  = '0;
        cost_d = '0;
        unique case (pick)
            PICK_RESET: begin
                kind_d = KIND_RESET;
                form_d = FORM_ADDR;
                tgt_d  = ADDR_W'(RESET_VEC);
                cost_d = COST_W'(RESET_COST);
            end
            PICK_NMI: begin
                kind_d = KIND_NMI;
                form_d = FORM_ADDR;
                tgt_d  = ADDR_W'(NMI_VEC);
                cost_d = COST_W'(NMI_COST);
            end
            PICK_INT: begin
                kind_d = KIND_INT;
                unique case (mode)
                    MODE_FIXED: begin
                        form_d = FORM_ADDR;
                        tgt_d  = ADDR_W'(FIXED_VEC);
                        cost_d = COST_W'(FIXED_COST);
                    end
                    MODE_TABLE: begin
                        form_d = FORM_TABLE;
                        tgt_d  = {vbase, bus_data};
                        cost_d = COST_W'(TABLE_COST);
                    end
                    default: begin
                        form_d = FORM_OPCODE;
                        tgt_d  = {{DATA_W{1'b0}}, bus_data};
                    end
                endcase
            end
            PICK_IDLE: begin
                form_d = FORM_OPCODE;
                cost_d = COST_W'(IDLE_COST);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take   <= 1'b0;
            kind   <= KIND_FETCH;
            form   <= FORM_NONE;
            target <= '0;
            cost   <= '0;
        end else begin
            take <= fire;
            if (fire) begin
                kind   <= kind_d;
                form   <= form_d;
                target <= tgt_d;
                cost   <= cost_d;
            end
        end
    end

    a_r2_nmi_fields: assert property (@(posedge clk) disable iff (!rst_n)
        fire && pick == PICK_NMI |=> take && target == 16'h0066 && cost == COST_W'(13));

    a_r6_table_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        fire && pick == PICK_INT && mode == MODE_TABLE
        |=> target == {$past(vbase), $past(bus_data)});

endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit
    import irq_gate_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int COST_W     = 5,
    parameter int VBASE_INIT = 'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boundary,
    input  logic                reset_req_n,
    input  logic                nmi_req_n,
    input  logic                int_req_n,
    input  logic [DATA_W-1:0]   bus_data,
    input  logic                ei_p,
    input  logic                di_p,
    input  logic                ret_p,
    input  logic                im_p,
    input  logic [2:0]          im_y,
    input  logic                vb_load,
    input  logic [DATA_W-1:0]   vb_data,
    input  logic                halt_cmd,
    output logic                take,
    output logic [1:0]          kind,
    output logic [1:0]          form,
    output logic [2*DATA_W-1:0] target,
    output logic [COST_W-1:0]   cost,
    output logic                halted,
    output logic                int_en,
    output logic                pv_flag,
    output logic [1:0]          im_mode,
    output logic [DATA_W-1:0]   vbase
);

    cpu_state_t state_q, state_d;
    pick_t      pick;
    int_mode_t  mode;
    take_kind_t kind_e;
    svc_form_t  form_e;
    logic       iff1, iff2;
    logic       acc_reset, acc_nmi, acc_int, leave;

    assign acc_reset = boundary && (pick == PICK_RESET);
    assign acc_nmi   = boundary && (pick == PICK_NMI);
    assign acc_int   = boundary && (pick == PICK_INT);
    assign leave     = acc_reset || acc_nmi || acc_int;

    irq_prio_select u_prio (
        .reset_req_n (reset_req_n),
        .nmi_req_n   (nmi_req_n),
        .int_req_n   (int_req_n),
        .iff1        (iff1),
        .halted      (state_q == ST_HALT),
        .pick        (pick)
    );

    irq_enable_regs #(.DATA_W(DATA_W), .VBASE_INIT(VBASE_INIT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ei_p      (ei_p),
        .di_p      (di_p),
        .ret_p     (ret_p),
        .im_p      (im_p),
        .im_y      (im_y),
        .vb_load   (vb_load),
        .vb_data   (vb_data),
        .acc_reset (acc_reset),
        .acc_nmi   (acc_nmi),
        .acc_int   (acc_int),
        .iff1      (iff1),
        .iff2      (iff2),
        .mode      (mode),
        .vbase     (vbase)
    );

    irq_service_gen #(.DATA_W(DATA_W), .COST_W(COST_W)) u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (boundary),
        .pick     (pick),
        .mode     (mode),
        .vbase    (vbase),
        .bus_data (bus_data),
        .take     (take),
        .kind     (kind_e),
        .form     (form_e),
        .target   (target),
        .cost     (cost)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (halt_cmd && !leave) state_d = ST_HALT;
            ST_HALT: if (leave)              state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        kind    = kind_e;
        form    = form_e;
        halted  = (state_q == ST_HALT);
        int_en  = iff1;
        pv_flag = iff2;
        im_mode = mode;
    end

    a_r1_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(boundary));

    a_r3_int_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        take && kind == 2'd2 |-> $past(int_en));

    a_r2_nmi_releases_halt: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && reset_req_n && !nmi_req_n |=> !halted);

    a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && halted && reset_req_n && nmi_req_n && (int_req_n || !int_en)
        |=> take && kind == 2'd3 && form == 2'd1 && halted);

endmodule

// File: tb/test_irq_gate_unit.sv
`timescale 1ns/1ps
module test_irq_gate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        reset_req_n = 1'b1, nmi_req_n = 1'b1, int_req_n = 1'b1;
    logic [7:0]  bus_data = 8'h00;
    logic        ei_p = 0, di_p = 0, ret_p = 0, im_p = 0, vb_load = 0, halt_cmd = 0;
    logic [2:0]  im_y = 3'd0;
    logic [7:0]  vb_data = 8'h00;
    logic        take, halted, int_en, pv_flag;
    logic [1:0]  kind, form, im_mode;
    logic [15:0] target;
    logic [4:0]  cost;
    logic [7:0]  vbase;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic       m_iff1 = 0, m_iff2 = 0, m_halt = 0;
    logic [1:0] m_mode = 0;
    logic [7:0] m_vb = 8'hFF;

    always #2 clk = ~clk;

    irq_gate_unit i_irq_gate_unit (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .reset_req_n(reset_req_n), .nmi_req_n(nmi_req_n), .int_req_n(int_req_n),
        .bus_data(bus_data), .ei_p(ei_p), .di_p(di_p), .ret_p(ret_p),
        .im_p(im_p), .im_y(im_y), .vb_load(vb_load), .vb_data(vb_data),
        .halt_cmd(halt_cmd), .take(take), .kind(kind), .form(form),
        .target(target), .cost(cost), .halted(halted), .int_en(int_en),
        .pv_flag(pv_flag), .im_mode(im_mode), .vbase(vbase)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [1:0] y_to_mode(input logic [2:0] y);
        if (y == 3'd2 || y == 3'd6) return 2'd1;
        if (y == 3'd3 || y == 3'd7) return 2'd2;
        return 2'd0;
    endfunction

    // op: 0 enable, 1 disable, 2 return, 3 mode select, 4 vbase load, 5 halt
    task automatic pulse(input int op, input logic [7:0] arg);
        case (op)
            0: ei_p = 1;
            1: di_p = 1;
            2: ret_p = 1;
            3: begin im_p = 1; im_y = arg[2:0]; end
            4: begin vb_load = 1; vb_data = arg; end
            default: halt_cmd = 1;
        endcase
        cyc();
        ei_p = 0; di_p = 0; ret_p = 0; im_p = 0; vb_load = 0; halt_cmd = 0;
        case (op)
            0: begin m_iff1 = 1; m_iff2 = 1; end
            1: begin m_iff1 = 0; m_iff2 = 0; end
            2: m_iff1 = m_iff2;
            3: m_mode = y_to_mode(arg[2:0]);
            4: m_vb = arg;
            default: m_halt = 1;
        endcase
    endtask

    task automatic state_chk(input string tag);
        chk({tag, " int_en"}, 16'(int_en), 16'(m_iff1));
        chk({tag, " pv_flag R11"}, 16'(pv_flag), 16'(m_iff2));
        chk({tag, " halted"}, 16'(halted), 16'(m_halt));
    endtask

    task automatic bnd(input logic r, input logic n, input logic i,
                       input logic [7:0] d, input string tag);
        logic [1:0] ek, ef;
        logic [15:0] et;
        logic [4:0] ec;
        if (!r) begin
            ek = 0; ef = 0; et = 16'h0000; ec = 3;
            m_iff1 = 0; m_iff2 = 0; m_halt = 0;
        end else if (!n) begin
            ek = 1; ef = 0; et = 16'h0066; ec = 13;
            m_iff1 = 0; m_halt = 0;
        end else if (!i && m_iff1) begin
            ek = 2;
            if (m_mode == 2'd1) begin ef = 0; et = 16'h0038; ec = 13; end
            else if (m_mode == 2'd2) begin ef = 2; et = {m_vb, d}; ec = 19; end
            else begin ef = 1; et = {8'h00, d}; ec = 0; end
            m_iff1 = 0; m_iff2 = 0; m_halt = 0;
        end else if (m_halt) begin
            ek = 3; ef = 1; et = 16'h0000; ec = 4;
        end else begin
            ek = 3; ef = 3; et = 16'h0000; ec = 0;
        end
        reset_req_n = r; nmi_req_n = n; int_req_n = i; bus_data = d; boundary = 1;
        cyc();
        boundary = 0; reset_req_n = 1; nmi_req_n = 1; int_req_n = 1;
        chk({tag, " take"}, 16'(take), 16'd1);
        chk({tag, " kind"}, 16'(kind), 16'(ek));
        chk({tag, " form"}, 16'(form), 16'(ef));
        chk({tag, " target"}, target, et);
        chk({tag, " cost"}, 16'(cost), 16'(ec));
        state_chk(tag);
        cyc();
        chk({tag, " take drop R1"}, 16'(take), 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog got hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 power-on state
        chk("R9 reset im_mode", 16'(im_mode), 16'd0);
        chk("R9 reset vbase", 16'(vbase), 16'h00FF);
        chk("R9 reset take", 16'(take), 16'd0);
        state_chk("R9 reset");

        // R10 plain fetch
        bnd(1, 1, 1, 8'h33, "R10 fetch");
        // R3 masked maskable falls through
        bnd(1, 1, 0, 8'h44, "R3 masked");

        // R11 vector base load
        pulse(4, 8'h12);
        chk("R11 vbase load", 16'(vbase), 16'h0012);

        // R8 mode map, R4 R5 R6 service in each mode
        for (int y = 0; y < 8; y++) begin
            pulse(3, 8'(y));
            chk("R8 mode map", 16'(im_mode), 16'(y_to_mode(3'(y))));
            for (int k = 0; k < 3; k++) begin
                logic [7:0] d;
                d = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : 8'hFF;
                pulse(0, 8'h00);
                chk("R7 enable", 16'(int_en), 16'd1);
                bnd(1, 1, 0, d, "R4 R5 R6 int mode");
            end
        end
        pulse(4, 8'hC3);
        pulse(3, 8'd7);
        pulse(0, 8'h00);
        bnd(1, 1, 0, 8'h9E, "R6 table pointer");

        // R2 NMI and R7 return
        pulse(0, 8'h00);
        bnd(1, 0, 1, 8'h00, "R2 nmi");
        pulse(2, 8'h00);
        chk("R7 return restores", 16'(int_en), 16'd1);
        pulse(1, 8'h00);
        chk("R7 disable iff1", 16'(int_en), 16'd0);
        chk("R7 disable iff2", 16'(pv_flag), 16'd0);

        // R1 requests without boundary are ignored
        pulse(0, 8'h00);
        nmi_req_n = 0; int_req_n = 0; reset_req_n = 0;
        for (int c = 0; c < 3; c++) begin
            cyc();
            chk("R1 no boundary take", 16'(take), 16'd0);
            chk("R1 no boundary int_en", 16'(int_en), 16'd1);
        end
        nmi_req_n = 1; int_req_n = 1; reset_req_n = 1;

        // R10 halted idle and release
        pulse(5, 8'h00);
        chk("R10 halted", 16'(halted), 16'd1);
        bnd(1, 1, 1, 8'h77, "R10 idle");
        bnd(1, 1, 1, 8'h77, "R10 idle again");
        bnd(1, 0, 1, 8'h00, "R2 nmi leaves halt");

        // R1 R3 R9 R10 priority sweep over requests, enable and halt
        for (int h = 0; h < 2; h++)
            for (int en = 0; en < 2; en++)
                for (int c = 0; c < 8; c++) begin
                    if (h == 1) pulse(5, 8'h00);
                    pulse(en == 1 ? 0 : 1, 8'h00);
                    bnd(c[2], c[1], c[0], 8'(8'hA0 + c), "R1 priority");
                end

        // R9 reset keeps mode and vector base
        chk("R9 reset keeps mode", 16'(im_mode), 16'(m_mode));
        chk("R9 reset keeps vbase", 16'(vbase), 16'(m_vb));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule